// File: doc/BRIEF.md
# Round-Robin Resource Allocator with Grant Hold

This block arbitrates a set of shared resources among many requesters in one clock cycle. Requesters are arranged as input ports, each with several channels. Every requester presents a one-hot vector that names the resource it wants, and a backpressure bit that blocks it while the downstream side cannot accept data. Each resource has its own round-robin arbiter. The arbiter results are folded back into a single grant bit per requester.

A requester that wins a resource keeps it in the following cycles for as long as it keeps asking for it, even if other requesters arrive. The grant is released only when the request drops or backpressure blocks the requester. This lets a multi-flit packet cross a virtual channel or an output port without being interleaved with another packet. The same block serves as the virtual-channel allocator and as the output stage of the switch allocator.

Requester index r = port*NumChan + chan orders the requesters for round-robin purposes.

Top module: `vc_hold_allocator`

## Requirements
- R1: For each resource, at most one requester holds a grant for it in any cycle.
- R2: A requester is granted only if its request vector is nonzero and its off bit is 0; an asserted off bit masks the request before arbitration.
- R3: The grant is combinational from the inputs: a new request can win in the same cycle that it is presented.
- R4: If at least one unmasked requester asks for a resource, some requester is granted that resource in the same cycle.
- R5: A requester granted resource s in one cycle that still requests s, unmasked, in the next cycle is granted again, whatever the other requests are.
- R6: Once the holder drops its request or is masked by its off bit, the resource is arbitrated afresh in that same cycle among the remaining requesters.
- R7: A fresh grant for a resource goes to the first requester at or after that resource's pointer, searching in increasing index order with wrap-around. The pointer then moves to the winner index plus one, wrapping at NumPorts*NumChan. The pointer moves only on a fresh grant, never while a grant is held.
- R8: Reset is asynchronous and active low. It clears every held grant and sets every pointer to requester 0, so that the lowest-index requester wins first.
- R9: Arbiters for different resources are independent, so requesters that ask for different resources can all be granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | NumPorts x NumChan x NumRes | One-hot wanted-resource vector per requester (all zero means no request) |
| offMask | input | NumPorts x NumChan | Backpressure bit per requester; 1 blocks it |
| grantVec | output | NumPorts x NumChan | Grant bit per requester |

## Verification
Several properties are checked on every cycle, next to the logic that they guard:
- each resource has at most one owner;
- no grant is given to a requester that is masked or idle;
- a resource with demand is always granted;
- a held owner keeps its grant while it still asks;
- a pointer stays still when no fresh grant is issued.

The exact round-robin order after releases and pointer wrap-around, the clearing of the pointers at reset and the independence of the resources can only be shown by the bench scenarios. There, directed hand-offs are mixed with long random request and backpressure traffic, and every cycle is compared against a reference model.

// File: rtl/rrha_pkg.sv
package rrha_pkg;

  // Per-resource command from the control to the datapath
  typedef struct packed {
    logic useHold;    // keep the registered owner this cycle
    logic pickFresh;  // take the round-robin result this cycle
  } arbStrobe_t;

endpackage

// File: rtl/rrha_rr_pick.sv
module rrha_rr_pick #(
  parameter int NumReq = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumReq-1:0] req,
  input  logic              advance,
  output logic [NumReq-1:0] oneHot
);
  localparam int PtrW = (NumReq > 1) ? $clog2(NumReq) : 1;
  localparam logic [PtrW-1:0] LastIdx = PtrW'(NumReq - 1);

  logic [PtrW-1:0] ptr;
  logic [PtrW-1:0] winIdx;
  logic            found;

  always_comb begin
    oneHot = '0;
    winIdx = ptr;
    found  = 1'b0;
    for (int k = 0; k < NumReq; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= NumReq) idx = idx - NumReq;
      if (!found && req[idx]) begin
        found       = 1'b1;
        winIdx      = PtrW'(idx);
        oneHot[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (advance && found) begin
      ptr <= (winIdx == LastIdx) ? '0 : winIdx + 1'b1;
    end
  end

  // R7: pointer frozen unless a fresh grant is taken
  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(ptr));

endmodule

// File: rtl/rrha_ctrl.sv
module rrha_ctrl
  import rrha_pkg::*;
#(
  parameter int NumReq = 20,
  parameter int NumRes = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NumRes-1:0][NumReq-1:0]  resReq,
  input  logic [NumRes-1:0][NumReq-1:0]  heldReq,
  output arbStrobe_t [NumRes-1:0]        strobes,
  output logic [NumRes-1:0][NumReq-1:0]  freshGrant
);

  for (genvar s = 0; s < NumRes; s++) begin : g_res
    logic anyHeld;
    logic anyReq;

    assign anyHeld              = |heldReq[s];
    assign anyReq               = |resReq[s];
    assign strobes[s].useHold   = anyHeld;
    assign strobes[s].pickFresh = !anyHeld && anyReq;

    rrha_rr_pick #(.NumReq(NumReq)) u_pick (
      .clk     (clk),
      .rstN    (rstN),
      .req     (resReq[s]),
      .advance (strobes[s].pickFresh),
      .oneHot  (freshGrant[s])
    );
  end

endmodule

// File: rtl/rrha_datapath.sv
module rrha_datapath
  import rrha_pkg::*;
#(
  parameter int NumPorts = 5,
  parameter int NumChan  = 4,
  parameter int NumRes   = 5
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic [NumPorts-1:0][NumChan-1:0][NumRes-1:0]  reqVec,
  input  logic [NumPorts-1:0][NumChan-1:0]              offMask,
  input  arbStrobe_t [NumRes-1:0]                       strobes,
  input  logic [NumRes-1:0][NumPorts*NumChan-1:0]       freshGrant,
  output logic [NumRes-1:0][NumPorts*NumChan-1:0]       resReq,
  output logic [NumRes-1:0][NumPorts*NumChan-1:0]       heldReq,
  output logic [NumPorts-1:0][NumChan-1:0]              grantVec
);
  localparam int NumReq = NumPorts * NumChan;

  logic [NumRes-1:0][NumReq-1:0] lastGrant;
  logic [NumRes-1:0][NumReq-1:0] arbOut;

  // regroup requests per resource, masked by backpressure
  for (genvar s = 0; s < NumRes; s++) begin : g_regroup
    for (genvar p = 0; p < NumPorts; p++) begin : g_port
      for (genvar c = 0; c < NumChan; c++) begin : g_chan
        assign resReq[s][p*NumChan + c] = reqVec[p][c][s] & ~offMask[p][c];
      end
    end
  end

  for (genvar s = 0; s < NumRes; s++) begin : g_sel
    assign heldReq[s] = lastGrant[s] & resReq[s];
    assign arbOut[s]  = strobes[s].useHold   ? heldReq[s]    :
                        strobes[s].pickFresh ? freshGrant[s] : '0;

    // R1: one owner per resource
    a_r1_single_owner: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(arbOut[s]));

    // R4: demand always served
    a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rstN)
      (|resReq[s]) |-> (|arbOut[s]));

    for (genvar r = 0; r < NumReq; r++) begin : g_req
      // R2: only unmasked requesters are granted
      a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rstN)
        arbOut[s][r] |-> resReq[s][r]);
      // R5: owner keeps the resource while still asking
      a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
        arbOut[s][r] |=> (resReq[s][r] |-> arbOut[s][r]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastGrant <= '0;
    else       lastGrant <= arbOut;
  end

  // fold per-resource results back to per-requester grants
  logic [NumReq-1:0] grantFlat;
  always_comb begin
    grantFlat = '0;
    for (int s = 0; s < NumRes; s++) grantFlat = grantFlat | arbOut[s];
  end

  for (genvar p = 0; p < NumPorts; p++) begin : g_out
    for (genvar c = 0; c < NumChan; c++) begin : g_oc
      assign grantVec[p][c] = grantFlat[p*NumChan + c];
    end
  end

endmodule

// File: rtl/vc_hold_allocator.sv
module vc_hold_allocator
  import rrha_pkg::*;
#(
  parameter int NumPorts = 5,
  parameter int NumChan  = 4,
  parameter int NumRes   = 5
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic [NumPorts-1:0][NumChan-1:0][NumRes-1:0]  reqVec,
  input  logic [NumPorts-1:0][NumChan-1:0]              offMask,
  output logic [NumPorts-1:0][NumChan-1:0]              grantVec
);
  localparam int NumReq = NumPorts * NumChan;

  arbStrobe_t [NumRes-1:0]        strobes;
  logic [NumRes-1:0][NumReq-1:0]  freshGrant;
  logic [NumRes-1:0][NumReq-1:0]  resReq;
  logic [NumRes-1:0][NumReq-1:0]  heldReq;

  rrha_datapath #(
    .NumPorts (NumPorts),
    .NumChan  (NumChan),
    .NumRes   (NumRes)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .offMask    (offMask),
    .strobes    (strobes),
    .freshGrant (freshGrant),
    .resReq     (resReq),
    .heldReq    (heldReq),
    .grantVec   (grantVec)
  );

  rrha_ctrl #(
    .NumReq (NumReq),
    .NumRes (NumRes)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resReq     (resReq),
    .heldReq    (heldReq),
    .strobes    (strobes),
    .freshGrant (freshGrant)
  );

  for (genvar p = 0; p < NumPorts; p++) begin : g_chk
    for (genvar c = 0; c < NumChan; c++) begin : g_chkc
      // R2: backpressure blocks the requester at the ports
      a_r2_off_blocks: assert property (@(posedge clk) disable iff (!rstN)
        offMask[p][c] |-> !grantVec[p][c]);
    end
  end

endmodule

// File: tb/vc_hold_allocator_bench.sv
module vc_hold_allocator_bench;
  localparam int N = 5;
  localparam int M = 4;
  localparam int S = 5;
  localparam int R = N * M;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0][M-1:0][S-1:0] reqVec = '0;
  logic [N-1:0][M-1:0]        offMask = '0;
  logic [N-1:0][M-1:0]        grantVec;

  vc_hold_allocator u_vc_hold_allocator (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .offMask  (offMask),
    .grantVec (grantVec)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;

  int reqOf [R];
  bit offB [R];
  int ptrM [S];
  bit lastM [S][R];
  bit expG [R];

  function automatic void modelReset();
    for (int s = 0; s < S; s++) begin
      ptrM[s] = 0;
      for (int r = 0; r < R; r++) lastM[s][r] = 1'b0;
    end
  endfunction

  // compute expected grants, and advance the model state as the clock edge will
  function automatic void modelStep();
    for (int r = 0; r < R; r++) expG[r] = 1'b0;
    for (int s = 0; s < S; s++) begin
      bit mreq [R];
      bit outv [R];
      bit anyHeld;
      anyHeld = 1'b0;
      for (int r = 0; r < R; r++) begin
        mreq[r] = (reqOf[r] == s) && !offB[r];
        outv[r] = 1'b0;
        if (lastM[s][r] && mreq[r]) begin
          anyHeld = 1'b1;
          outv[r] = 1'b1;
        end
      end
      if (!anyHeld) begin
        for (int k = 0; k < R; k++) begin
          int idx;
          idx = (ptrM[s] + k) % R;
          if (mreq[idx]) begin
            outv[idx] = 1'b1;
            ptrM[s] = (idx + 1) % R;
            break;
          end
        end
      end
      for (int r = 0; r < R; r++) begin
        lastM[s][r] = outv[r];
        if (outv[r]) expG[r] = 1'b1;
      end
    end
  endfunction

  task automatic drive();
    for (int r = 0; r < R; r++) begin
      reqVec[r / M][r % M] = (reqOf[r] >= 0) ? (S'(1) << reqOf[r]) : '0;
      offMask[r / M][r % M] = offB[r];
    end
  endtask

  function automatic logic [R-1:0] gotFlat();
    logic [R-1:0] v;
    for (int r = 0; r < R; r++) v[r] = grantVec[r / M][r % M];
    return v;
  endfunction

  task automatic check(string tag, logic [R-1:0] got, logic [R-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample mid-cycle, then step the model
  task automatic step(string tag);
    logic [R-1:0] e;
    logic [R-1:0] g;
    drive();
    #2;
    modelStep();
    for (int r = 0; r < R; r++) e[r] = expG[r];
    g = gotFlat();
    check(tag, g, e);
    // R1 and R2 structural checks at the ports
    for (int s = 0; s < S; s++) begin
      int cnt;
      cnt = 0;
      for (int r = 0; r < R; r++) if (g[r] && reqOf[r] == s) cnt++;
      total++;
      if (cnt > 1) begin
        bad++;
        $display("FAIL R1: resource %0d owners=%0d expected<=1", s, cnt);
      end
    end
    for (int r = 0; r < R; r++) begin
      if (g[r] && (reqOf[r] < 0 || offB[r])) begin
        total++;
        bad++;
        $display("FAIL R2: requester %0d granted=1 expected=0", r);
      end
    end
    @(negedge clk);
  endtask

  task automatic clearAll();
    for (int r = 0; r < R; r++) begin
      reqOf[r] = -1;
      offB[r] = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clearAll();
    modelReset();
    drive();
    repeat (3) @(negedge clk);
    // R8: outputs idle during reset
    check("R8 reset idle", gotFlat(), '0);
    rstN = 1'b1;
    @(negedge clk);
    step("R8 idle after reset");

    // R8, R3: everyone asks for resource 0, requester 0 wins at once
    for (int r = 0; r < R; r++) reqOf[r] = 0;
    drive();
    #2;
    check("R8 first winner is requester 0", gotFlat(), R'(1));
    #0;
    @(negedge clk);
    // re-run this cycle through the model for consistency
    modelReset();
    rstN = 1'b0;
    clearAll();
    drive();
    #2;
    rstN = 1'b1;
    @(negedge clk);
    for (int r = 0; r < R; r++) reqOf[r] = 0;
    step("R7 fresh win from pointer 0");
    // R5: owner 0 keeps it against 19 contenders
    drive();
    #2;
    check("R5 hold requester 0", gotFlat(), R'(1));
    #0;
    @(negedge clk);
    modelStep();
    // R6, R7: owner drops, next in order is requester 1
    reqOf[0] = -1;
    drive();
    #2;
    check("R6 release to requester 1", gotFlat(), R'(2));
    @(negedge clk);
    modelStep();
    // R5: requester 0 returns but 1 holds
    reqOf[0] = 0;
    step("R5 hold against returning requester");
    // R6: owner 1 drops, pointer is at 2
    reqOf[1] = -1;
    drive();
    #2;
    check("R7 next after pointer is requester 2", gotFlat(), R'(4));
    @(negedge clk);
    modelStep();
    // R2, R6: backpressure on owner 2 hands resource to 3
    offB[2] = 1'b1;
    step("R2 off releases owner");
    offB[2] = 1'b0;
    step("R5 owner 3 keeps after off clears");

    // R9: independent resources in one cycle
    clearAll();
    step("R6 all idle");
    reqOf[0] = 1;
    reqOf[5] = 2;
    reqOf[19] = 4;
    drive();
    #2;
    check("R9 independent resources", gotFlat(), (R'(1) << 0) | (R'(1) << 5) | (R'(1) << 19));
    @(negedge clk);
    modelStep();

    // R7: wrap-around of a pointer near the top index
    clearAll();
    step("R7 idle");
    reqOf[18] = 3;
    step("R7 requester 18 wins resource 3");
    reqOf[18] = -1;
    reqOf[4] = 3;
    reqOf[19] = 3;
    step("R7 pointer 19 prefers requester 19");
    reqOf[19] = -1;
    step("R7 wrap to requester 4");

    // R4, R5, R7: random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int r = 0; r < R; r++) begin
        if (reqOf[r] < 0) begin
          if ($urandom_range(99) < 30) reqOf[r] = int'($urandom_range(S - 1));
        end else if ($urandom_range(99) < 15) begin
          reqOf[r] = -1;
        end
        offB[r] = ($urandom_range(99) < 8);
      end
      step("R4 random traffic");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule